// File: doc/BRIEF.md
# Accumulator and Extend-Bit Unit

This block holds a 16-bit working accumulator together with a single extend bit that catches the carry from addition and acts as the seventeenth bit of the rotate operations. Each clock cycle, a one-hot operation select picks one transformation of the accumulator and the extend bit. The transformation can use a 16-bit data operand and an 8-bit character input. The result is written back on the next rising clock edge. When no select is raised, both registers keep their values.

Four status outputs are derived from the registered state for use by conditional-skip logic elsewhere:

- sign clear
- sign set
- accumulator all zero
- extend bit zero

Instruction decoding, memory access and program sequencing are outside this block. The surrounding control guarantees that at most one select bit is high in any cycle.

Top module: `acc_ext_unit`

## Requirements
- R1: A clock edge with `rst_n` low clears the accumulator and the extend bit to zero.
- R2: With `op_sel` bit 0 (logical AND) high, the accumulator becomes the bitwise AND of itself and `dr_i`. The extend bit is kept.
- R3: With `op_sel` bit 1 (add) high, the accumulator becomes the low 16 bits of accumulator plus `dr_i`, and the extend bit receives the carry out of bit 15.
- R4: With `op_sel` bit 2 (load) high, the accumulator takes `dr_i` unchanged. The extend bit is kept.
- R5: With `op_sel` bit 3 (character input) high, accumulator bits 7..0 take `chr_i` and bits 15..8 are kept. The extend bit is kept.
- R6: With `op_sel` bit 6 (rotate right) high, the 17-bit value {extend, accumulator} rotates right by one: the old extend bit enters bit 15 and the old bit 0 enters the extend bit.
- R7: With `op_sel` bit 7 (rotate left) high, {extend, accumulator} rotates left by one: the old extend bit enters bit 0 and the old bit 15 enters the extend bit.
- R8: With `op_sel` bit 4 (clear) high, the accumulator becomes zero. With `op_sel` bit 5 (invert) high, every accumulator bit is inverted. In both cases the extend bit is kept.
- R9: With `op_sel` bit 8 (increment) high, the accumulator is increased by one, wrapping from 0xFFFF to 0x0000. The extend bit is kept.
- R10: With `op_sel` bit 9 high, the extend bit is cleared. With `op_sel` bit 10 high, the extend bit is inverted. In both cases the accumulator is kept.
- R11: With `op_sel` all zero, the accumulator and the extend bit keep their values.
- R12: The status outputs follow the registered state in the same cycle:
  - `acc_pos` is high when accumulator bit 15 is 0.
  - `acc_neg` is high when bit 15 is 1.
  - `acc_zero` is high when the accumulator is zero.
  - `ext_zero` is high when the extend bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_i | input | 16 | Data operand for AND, add and load |
| chr_i | input | 8 | Character written into the low byte |
| op_sel | input | 11 | One-hot operation select, bit meanings in R2 to R10 |
| acc_o | output | 16 | Registered accumulator |
| ext_o | output | 1 | Registered extend bit |
| acc_pos | output | 1 | Accumulator sign bit clear |
| acc_neg | output | 1 | Accumulator sign bit set |
| acc_zero | output | 1 | Accumulator equals zero |
| ext_zero | output | 1 | Extend bit equals zero |

## Verification
Every operation takes effect at the first rising edge at which its select is sampled, so `acc_o` and `ext_o` carry the new value exactly one cycle after the stimulus. The status flags are combinational from those registers and change in that same cycle. The bench drives inputs on the falling edge and compares all six outputs on the following falling edge, after the single rising edge has passed. It checks against a 17-bit reference of {extend, accumulator} that it updates alongside the stimulus. Directed cases cover:

- carry out of an add
- increment wrap
- rotates with each extend value
- the preserved high byte on character input

A long random run then mixes all operations with idle cycles.

// File: rtl/acc_ext_pkg.sv
// Shared definitions for the accumulator/extend unit.
// Assumes the select vector is one-hot or zero; the bit positions
// below are the external encoding of op_sel.
package acc_ext_pkg;
    localparam int OP_AND  = 0;
    localparam int OP_ADD  = 1;
    localparam int OP_LOAD = 2;
    localparam int OP_CHR  = 3;
    localparam int OP_CLR  = 4;
    localparam int OP_INV  = 5;
    localparam int OP_ROR  = 6;
    localparam int OP_ROL  = 7;
    localparam int OP_INC  = 8;
    localparam int OP_ECLR = 9;
    localparam int OP_EINV = 10;
    localparam int N_OPS   = 11;
endpackage

// File: rtl/acc_ext_adder.sv
// Ripple-free behavioural adder with carry out, shared by the add and
// increment operations. Assumes unsigned operands of equal width.
module acc_ext_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Widened sum so the carry falls out as the top bit.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b};
    end
endmodule

// File: rtl/acc_ext_datapath.sv
// Next-state network: builds one candidate {extend, accumulator} value
// per operation and selects among them with an AND-OR mux driven by the
// one-hot select. Assumes at most one select bit is high.
module acc_ext_datapath
    import acc_ext_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic [W-1:0]     acc,
    input  logic             ext,
    input  logic [W-1:0]     dr,
    input  logic [IN_W-1:0]  chr,
    input  logic [N_OPS-1:0] sel,
    output logic [W-1:0]     nxt_acc,
    output logic             nxt_ext,
    output logic             load_en
);
    localparam int SW = W + 1;

    logic [W-1:0] add_b;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [SW-1:0] cand [N_OPS];
    logic [SW-1:0] acc_or [N_OPS+1];

    // Second adder operand: constant one for increment, else data operand.
    always_comb begin
        add_b = sel[OP_INC] ? {{(W-1){1'b0}}, 1'b1} : dr;
    end

    acc_ext_adder #(.W(W)) u_adder (
        .a    (acc),
        .b    (add_b),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Candidate results, one per operation, in {extend, accumulator} form.
    always_comb begin
        cand[OP_AND]  = {ext, acc & dr};
        cand[OP_ADD]  = {add_cout, add_sum};
        cand[OP_LOAD] = {ext, dr};
        cand[OP_CHR]  = {ext, acc[W-1:IN_W], chr};
        cand[OP_CLR]  = {ext, {W{1'b0}}};
        cand[OP_INV]  = {ext, ~acc};
        cand[OP_ROR]  = {acc[0], ext, acc[W-1:1]};
        cand[OP_ROL]  = {acc[W-1], acc[W-2:0], ext};
        cand[OP_INC]  = {ext, add_sum};
        cand[OP_ECLR] = {1'b0, acc};
        cand[OP_EINV] = {~ext, acc};
    end

    assign acc_or[0] = '0;

    generate
        for (genvar i = 0; i < N_OPS; i++) begin : g_mux
            // Mask each candidate with its select and fold into the OR chain.
            assign acc_or[i+1] = acc_or[i] | (cand[i] & {SW{sel[i]}});
        end
    endgenerate

    // Register write enable and split of the selected value.
    always_comb begin
        load_en = |sel;
        {nxt_ext, nxt_acc} = acc_or[N_OPS];
    end
endmodule

// File: rtl/acc_ext_status.sv
// Status flags for conditional-skip logic, derived from registered state.
// Assumes bit W-1 of the accumulator is the sign.
module acc_ext_status #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic         ext,
    output logic         pos,
    output logic         neg,
    output logic         zero,
    output logic         ezero
);
    // Flags decoded from the current register contents.
    always_comb begin
        pos   = ~acc[W-1];
        neg   = acc[W-1];
        zero  = ~|acc;
        ezero = ~ext;
    end
endmodule

// File: rtl/acc_ext_unit.sv
// Top level: accumulator and extend registers, the next-state network and
// the status decode. Synchronous active-low reset clears both registers.
// Assumes the caller keeps op_sel one-hot or zero.
module acc_ext_unit
    import acc_ext_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     dr_i,
    input  logic [IN_W-1:0]  chr_i,
    input  logic [N_OPS-1:0] op_sel,
    output logic [W-1:0]     acc_o,
    output logic             ext_o,
    output logic             acc_pos,
    output logic             acc_neg,
    output logic             acc_zero,
    output logic             ext_zero
);
    logic [W-1:0] acc_q;
    logic         ext_q;
    logic [W-1:0] nxt_acc;
    logic         nxt_ext;
    logic         load_en;

    acc_ext_datapath #(.W(W), .IN_W(IN_W)) u_dp (
        .acc     (acc_q),
        .ext     (ext_q),
        .dr      (dr_i),
        .chr     (chr_i),
        .sel     (op_sel),
        .nxt_acc (nxt_acc),
        .nxt_ext (nxt_ext),
        .load_en (load_en)
    );

    // State registers: clear on reset, write when any operation is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ext_q <= 1'b0;
        end else if (load_en) begin
            acc_q <= nxt_acc;
            ext_q <= nxt_ext;
        end
    end

    acc_ext_status #(.W(W)) u_status (
        .acc   (acc_q),
        .ext   (ext_q),
        .pos   (acc_pos),
        .neg   (acc_neg),
        .zero  (acc_zero),
        .ezero (ext_zero)
    );

    assign acc_o = acc_q;
    assign ext_o = ext_q;
endmodule

// File: rtl/acc_ext_unit_chk.sv
// Protocol and behaviour checker for acc_ext_unit, attached by bind.
module acc_ext_unit_chk
    import acc_ext_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     dr_i,
    input logic [IN_W-1:0]  chr_i,
    input logic [N_OPS-1:0] op_sel,
    input logic [W-1:0]     acc_o,
    input logic             ext_o,
    input logic             acc_zero,
    input logic             acc_neg
);
    // Input contract: at most one operation per cycle.
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_sel));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == '0) |=> ($stable(acc_o) && $stable(ext_o)));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[OP_ADD] |=> ({ext_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(dr_i)})));

    // R5
    chr_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[OP_CHR] |=> (acc_o[IN_W-1:0] == $past(chr_i)
                            && acc_o[W-1:IN_W] == $past(acc_o[W-1:IN_W])));

    // R9
    inc_keeps_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[OP_INC] |=> (ext_o == $past(ext_o) && acc_o == $past(acc_o) + 1'b1));

    // R10
    ext_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[OP_EINV] |=> (ext_o != $past(ext_o) && $stable(acc_o)));

    // R12
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_zero == (acc_o == '0));

    // R12
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_neg == acc_o[W-1]);
endmodule

bind acc_ext_unit acc_ext_unit_chk #(.W(W), .IN_W(IN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dr_i     (dr_i),
    .chr_i    (chr_i),
    .op_sel   (op_sel),
    .acc_o    (acc_o),
    .ext_o    (ext_o),
    .acc_zero (acc_zero),
    .acc_neg  (acc_neg)
);

// File: tb/acc_ext_unit_bench.sv
module acc_ext_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dr_i = '0;
    logic [7:0]  chr_i = '0;
    logic [10:0] op_sel = '0;
    logic [15:0] acc_o;
    logic        ext_o, acc_pos, acc_neg, acc_zero, ext_zero;

    int checks = 0;
    int errors = 0;
    logic [16:0] mdl = '0;   // reference {extend, accumulator}
    bit done = 0;

    always #2.5 clk = ~clk;

    acc_ext_unit u_acc_ext_unit (
        .clk(clk), .rst_n(rst_n), .dr_i(dr_i), .chr_i(chr_i), .op_sel(op_sel),
        .acc_o(acc_o), .ext_o(ext_o), .acc_pos(acc_pos), .acc_neg(acc_neg),
        .acc_zero(acc_zero), .ext_zero(ext_zero)
    );

    function automatic string tag_of(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 5: return "R8";
            6: return "R6";
            7: return "R7";
            8: return "R9";
            9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "ext_acc", {ext_o, acc_o}, mdl);
        check("R12", "pos", {16'd0, acc_pos}, {16'd0, ~mdl[15]});
        check("R12", "neg", {16'd0, acc_neg}, {16'd0, mdl[15]});
        check("R12", "zero", {16'd0, acc_zero}, {16'd0, mdl[15:0] == 16'd0});
        check("R12", "ezero", {16'd0, ext_zero}, {16'd0, ~mdl[16]});
    endtask

    // Apply one operation (op<0 means idle) and compare one edge later.
    task automatic step(int op, logic [15:0] d, logic [7:0] c);
        logic [16:0] nx;
        logic [15:0] a;
        logic e;
        @(negedge clk);
        dr_i = d; chr_i = c;
        op_sel = (op >= 0) ? (11'd1 << op) : 11'd0;
        a = mdl[15:0]; e = mdl[16];
        case (op)
            0: nx = {e, a & d};
            1: nx = {1'b0, a} + {1'b0, d};
            2: nx = {e, d};
            3: nx = {e, a[15:8], c};
            4: nx = {e, 16'd0};
            5: nx = {e, ~a};
            6: nx = {a[0], e, a[15:1]};
            7: nx = {a[15], a[14:0], e};
            8: nx = {e, a + 16'd1};
            9: nx = {1'b0, a};
            10: nx = {~e, a};
            default: nx = mdl;
        endcase
        mdl = nx;
        @(negedge clk);
        op_sel = '0;
        compare_all(tag_of(op));
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0;
        op_sel = 11'h001; dr_i = 16'h1234;   // ignored under reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        op_sel = '0;
        mdl = '0;
        compare_all("R1");

        step(2, 16'hFFFF, 8'h00);        // R4 load all ones
        step(1, 16'h0001, 8'h00);        // R3 carry out, sum wraps to 0
        step(-1, 16'hAAAA, 8'h55);       // R11 idle holds E=1
        step(7, 16'h0, 8'h0);            // R7 rotate left with E=1
        step(6, 16'h0, 8'h0);            // R6 rotate right restores
        step(2, 16'h8001, 8'h0);         // R4
        step(6, 16'h0, 8'h0);            // R6 bit0 into E
        step(7, 16'h0, 8'h0);            // R7 bit15 into E
        step(3, 16'h0, 8'hC3);           // R5 low byte only
        step(0, 16'h0FF0, 8'h0);         // R2 AND
        step(5, 16'h0, 8'h0);            // R8 invert
        step(10, 16'h0, 8'h0);           // R10 invert E
        step(9, 16'h0, 8'h0);            // R10 clear E
        step(2, 16'hFFFF, 8'h0);
        step(8, 16'h0, 8'h0);            // R9 wrap, E kept
        step(4, 16'h0, 8'h0);            // R8 clear
        step(1, 16'h7FFF, 8'h0);         // R3 no carry
        step(1, 16'h0001, 8'h0);         // R3 sign becomes set
        step(-1, 16'h0, 8'h0);           // R11

        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom_range(0, 11)) - 1;
            step(op, 16'($urandom), 8'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule